// File: doc/BRIEF.md
# Multi-Lane Stochastic Bit Shuffler

This block takes a group of P parallel stochastic bit streams that all stand for the same probability and re-randomizes them so that neighbouring lanes stay decorrelated. Each lane owns one JK flip-flop that normalizes the pair of control bits it receives. It needs no edge memory and no random source. When a lane sees no control activity in a decoding cycle (J=K=0), its output is not a stale copy of its own state. It is taken instead from a sibling lane, chosen through a combinational circular rotator whose shift amount moves on by one every decoding cycle.

Logic upstream presents the J and K bits of every lane and pulses `step` once per decoding cycle. One cycle after each strobe, the block's registered output carries P fresh stochastic bits. Between strobes, every piece of state holds. Since P streams carry one probability, the number of decoding cycles needed for a given precision falls by the factor P. The default is P = 8, and P must be at least 3.

Top module: `stoch_shuffler`

## Requirements
- R1: On a clock edge with `step`=1, each lane's state bit follows the JK rule: J=1,K=0 sets it to 1; J=0,K=1 clears it to 0; J=1,K=1 inverts it; J=0,K=0 keeps it.
- R2: A lane with J=1 or K=1 at a strobe is regenerative. After that edge its output bit equals its own newly updated state bit.
- R3: A lane i with J=K=0 at a strobe is non-regenerative. After that edge its output bit equals the newly updated state bit of lane (i + r) mod P, where r is the rotation amount in effect at that strobe.
- R4: The rotation amount r is 1 after reset. Each strobe moves it on by one through 1, 2, ..., P-1, and from P-1 it wraps back to 1. It never takes the value 0, so a lane never selects itself.
- R5: On an edge with `step`=0, the state bits, the outputs and the rotation amount all keep their values, whatever `j_in` and `k_in` carry.
- R6: A synchronous active-high `rst` clears every state bit and every output bit to 0 and sets r to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Decoding-cycle strobe |
| j_in | input | P | J control bit, one per lane (bit i = lane i) |
| k_in | input | P | K control bit, one per lane (bit i = lane i) |
| stoch_out | output | P | Registered stochastic output bit per lane |

## Verification
On every cycle, the checker covers these properties:
- the JK set, clear and toggle rules of R1, lane by lane;
- the regenerative output of R2;
- the rotation sequence and the bar on a zero rotation of R4;
- holding between strobes (R5) and clearing after reset (R6).

The sibling selection of R3 depends on both the rotation amount and the state of another lane, so only the bench's scoreboard shows it. Its scenarios make single lanes regenerative one at a time across a full wrap of the rotation, apply random mixtures of J/K activity, and repeat one pattern straight after reset to show that the rotation restarts at 1.

// File: rtl/stoch_shuf_pkg.sv
package stoch_shuf_pkg;

    typedef enum logic [1:0] {
        JK_KEEP  = 2'b00,
        JK_CLEAR = 2'b01,
        JK_SET   = 2'b10,
        JK_FLIP  = 2'b11
    } jk_action_e;

    function automatic jk_action_e jk_decode(input logic j, input logic k);
        return jk_action_e'({j, k});
    endfunction

    function automatic logic jk_apply(input jk_action_e act, input logic cur);
        logic res;
        case (act)
            JK_SET:   res = 1'b1;
            JK_CLEAR: res = 1'b0;
            JK_FLIP:  res = ~cur;
            default:  res = cur;
        endcase
        return res;
    endfunction

    function automatic int unsigned rot_advance(input int unsigned cur, input int unsigned lanes);
        return (cur >= lanes - 1) ? 1 : cur + 1;
    endfunction

endpackage

// File: rtl/stoch_jk_lane.sv
module stoch_jk_lane
    import stoch_shuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic j,
    input  logic k,
    output logic q,
    output logic q_next,
    output logic regen
);

    jk_action_e act;

    always_comb begin
        act    = jk_decode(j, k);
        q_next = jk_apply(act, q);
        regen  = (act != JK_KEEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (step) begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/stoch_rot_counter.sv
module stoch_rot_counter
    import stoch_shuf_pkg::*;
#(
    parameter int unsigned P  = 8,
    localparam int unsigned RW = $clog2(P)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [RW-1:0] rot
);

    logic [RW-1:0] rot_nxt;

    always_comb begin
        rot_nxt = RW'(rot_advance(int'(rot), P));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rot <= RW'(1);
        end else if (step) begin
            rot <= rot_nxt;
        end
    end

endmodule

// File: rtl/stoch_barrel_rot.sv
module stoch_barrel_rot #(
    parameter int unsigned P  = 8,
    localparam int unsigned RW = $clog2(P)
) (
    input  logic [P-1:0]  din,
    input  logic [RW-1:0] amt,
    output logic [P-1:0]  dout
);

    logic [2*P-1:0] doubled;
    logic [2*P-1:0] shifted;

    always_comb begin
        doubled = {din, din};
        shifted = doubled >> amt;
        dout    = shifted[P-1:0];
    end

endmodule

// File: rtl/stoch_shuffler.sv
module stoch_shuffler #(
    parameter int unsigned P  = 8,
    localparam int unsigned RW = $clog2(P)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [P-1:0] j_in,
    input  logic [P-1:0] k_in,
    output logic [P-1:0] stoch_out
);

    logic [P-1:0]  state_q;
    logic [P-1:0]  state_nxt;
    logic [P-1:0]  regen_vec;
    logic [P-1:0]  rotated;
    logic [P-1:0]  picked;
    logic [RW-1:0] rot_q;

    for (genvar g = 0; g < P; g++) begin : g_lane
        stoch_jk_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .step   (step),
            .j      (j_in[g]),
            .k      (k_in[g]),
            .q      (state_q[g]),
            .q_next (state_nxt[g]),
            .regen  (regen_vec[g])
        );
        assign picked[g] = regen_vec[g] ? state_nxt[g] : rotated[g];
    end

    stoch_rot_counter #(.P(P)) u_rot (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .rot  (rot_q)
    );

    stoch_barrel_rot #(.P(P)) u_barrel (
        .din  (state_nxt),
        .amt  (rot_q),
        .dout (rotated)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stoch_out <= '0;
        end else if (step) begin
            stoch_out <= picked;
        end
    end

endmodule

// File: rtl/stoch_shuffler_chk.sv
module stoch_shuffler_chk
    import stoch_shuf_pkg::*;
#(
    parameter int unsigned P  = 8,
    localparam int unsigned RW = $clog2(P)
) (
    input logic          clk,
    input logic          rst,
    input logic          step,
    input logic [P-1:0]  j_in,
    input logic [P-1:0]  k_in,
    input logic [P-1:0]  state,
    input logic [P-1:0]  out_q,
    input logic [RW-1:0] rot
);

    assert_rot_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        rot != '0);

    assert_rot_advance_R4: assert property (@(posedge clk) disable iff (rst)
        step |=> int'(rot) == rot_advance(int'($past(rot)), P));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(state) && $stable(out_q) && $stable(rot));

    assert_reset_R6: assert property (@(posedge clk)
        rst |=> (state == '0) && (out_q == '0) && (rot == RW'(1)));

    for (genvar g = 0; g < P; g++) begin : g_chk
        assert_set_R1: assert property (@(posedge clk) disable iff (rst)
            step && j_in[g] && !k_in[g] |=> state[g]);

        assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
            step && !j_in[g] && k_in[g] |=> !state[g]);

        assert_toggle_R1: assert property (@(posedge clk) disable iff (rst)
            step && j_in[g] && k_in[g] |=> state[g] != $past(state[g]));

        assert_regen_out_R2: assert property (@(posedge clk) disable iff (rst)
            step && (j_in[g] || k_in[g]) |=> out_q[g] == state[g]);
    end

endmodule

bind stoch_shuffler stoch_shuffler_chk #(.P(P)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .step  (step),
    .j_in  (j_in),
    .k_in  (k_in),
    .state (state_q),
    .out_q (stoch_out),
    .rot   (rot_q)
);

// File: tb/stoch_shuffler_tb.sv
`timescale 1ns/1ps
module stoch_shuffler_tb;

    localparam int unsigned P = 8;

    typedef struct {
        logic [P-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         step = 1'b0;
    logic [P-1:0] j_in = '0;
    logic [P-1:0] k_in = '0;
    logic [P-1:0] stoch_out;

    item_t        sb_q[$];
    logic [P-1:0] m_state;
    int unsigned  m_rot;
    logic [P-1:0] last_exp;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    stoch_shuffler #(.P(P)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .j_in      (j_in),
        .k_in      (k_in),
        .stoch_out (stoch_out)
    );

    // monitor: results land on the posedge after a queued stimulus
    initial begin
        forever begin
            item_t it;
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_checks++;
                if (stoch_out !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: stoch_out=%b expected=%b", it.tag, stoch_out, it.exp);
                end
            end
        end
    end

    task automatic strobe(input logic [P-1:0] j, input logic [P-1:0] k, input string tag);
        logic [P-1:0] nxt;
        logic [P-1:0] e;
        item_t it;
        for (int i = 0; i < P; i++) begin
            case ({j[i], k[i]})
                2'b10:   nxt[i] = 1'b1;
                2'b01:   nxt[i] = 1'b0;
                2'b11:   nxt[i] = ~m_state[i];
                default: nxt[i] = m_state[i];
            endcase
        end
        for (int i = 0; i < P; i++) begin
            e[i] = (j[i] | k[i]) ? nxt[i] : nxt[(i + m_rot) % P];
        end
        m_state  = nxt;
        m_rot    = (m_rot == P - 1) ? 1 : m_rot + 1;
        last_exp = e;
        j_in = j;
        k_in = k;
        step = 1'b1;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic idle(input string tag);
        item_t it;
        j_in = P'($urandom);
        k_in = P'($urandom);
        step = 1'b0;
        it.exp = last_exp;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        step = 1'b0;
        j_in = P'($urandom);
        k_in = P'($urandom);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_state  = '0;
        m_rot    = 1;
        last_exp = '0;
        n_checks++;
        if (stoch_out !== '0) begin
            n_fail++;
            $display("FAIL R6: stoch_out=%b expected=%b", stoch_out, {P{1'b0}});
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();                                  // R6 reset state

        strobe(8'hFF, 8'h00, "R1 set all");
        strobe(8'h00, 8'hFF, "R1 clear all");
        strobe(8'hFF, 8'hFF, "R1 toggle all");
        strobe(8'h5A, 8'h5A, "R1 toggle some");
        strobe(8'hC3, 8'h3C, "R2 set/clear mix");

        // R3: one regenerative lane at a time across a full rotation wrap
        for (int n = 0; n < 2 * P; n++) begin
            strobe(P'(1) << (n % P), 8'h00, "R3 single lane");
        end
        strobe(8'h00, 8'h00, "R3 all idle lanes");
        strobe(8'h00, 8'h00, "R3 all idle lanes");

        idle("R5 hold");
        idle("R5 hold");
        idle("R5 hold");
        strobe(8'h00, 8'h01, "R5 after hold");

        for (int n = 0; n < 40; n++) begin
            strobe(P'($urandom), P'($urandom) & P'($urandom), "R3 random mix");
            if (n % 7 == 3) idle("R5 hold random");
        end

        do_reset();                                  // R6 mid-run
        strobe(8'h01, 8'h00, "R4 rotation restarts at 1");
        strobe(8'h02, 8'h00, "R4 rotation second step");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule